// File: doc/BRIEF.md
# Nonvolatile Save/Restore Sequencer

This block is the mode controller for a static memory array that keeps a nonvolatile shadow copy. It decides when the array is refilled from the shadow (restore) and when the shadow is rewritten from the array (save), and it closes access to the array while either runs. A restore has two phases: the array is cleared, then the shadow contents are copied in. A save also has two phases: the old shadow contents are erased, then the shadow is programmed from the array.

A restore starts when power comes good and when software asks for one. A save starts when software asks for one, which always runs. It also starts when power fails or when something outside holds the shared busy line low, and those two run only if a write has landed since the last save. The busy line is open-drain. The block reads its level on one input and pulls it low through a drive-enable output for the whole of each save, so several arrays can share one line and save together. Every duration is a parameter in clock cycles.

Top module: `nvsr_seq`

## Requirements
- R1: After reset, with power not good, `inhibit` and `wr_block` are 1, `busy_drive_lo` is 0, and no pulse output is high.
- R2: With power not good, a rise of `pwr_ok` gives `clr_pulse` in cycle k=1, where k counts clock edges after the input change. It gives `copy_pulse` at k=CLR_CYC+1. `inhibit` falls at k=CLR_CYC+PUP_CYC+1.
- R3: A `sw_recall_req` pulse during open access gives `clr_pulse` at k=1, and `inhibit` falls at k=CLR_CYC+SWR_CYC+1.
- R4: A `sw_store_req` pulse during open access starts a save even with no write since the last save. `busy_drive_lo` is 1 from k=1 to k=ERASE_CYC+PROG_CYC, and `save_strobe` pulses at k=ERASE_CYC+1.
- R5: After a save that ends with power good, `inhibit` stays 1 while the busy line is low. It falls REC_CYC+1 cycles after the line reads high.
- R6: The busy line held low from outside for ASSERT_CYC consecutive cycles during open access opens a delay window at k=ASSERT_CYC. The window lasts DLY_CYC cycles, with `inhibit`=0 and `wr_block`=1.
- R7: An `acc_evt` pulse inside the delay window ends it at the next edge, and the save starts there when a write is pending.
- R8: A write strobe inside the delay window, or at any time access is not fully open, does not count as a write.
- R9: A busy-line request with no pending write does not save. At the end of the window `inhibit`=1 and `busy_drive_lo`=0 until the line reads high, and then recovery follows as in R5.
- R10: If power drops during open access with a write pending, the line is driven low at k=1 as a save attempt, and the erase starts at k=2. `save_strobe` pulses at k=ERASE_CYC+2 and the line is released at k=ERASE_CYC+PROG_CYC+2, with `inhibit` held at 1.
- R11: A power drop with no pending write goes to the off state at k=1 without driving the line.
- R12: If the busy line still reads high at the end of the one-cycle save attempt, the attempt is abandoned: the line is released at k=2 and no `save_strobe` is issued.
- R13: Software requests and busy-line requests are ignored when power is not good or a save or restore is running.
- R14: The pending-write flag is set by `wr_strobe` during open access (delay window excluded) and cleared when a save completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | High while supply is above the switch threshold |
| sw_store_req | input | 1 | One-cycle software save request |
| sw_recall_req | input | 1 | One-cycle software restore request |
| wr_strobe | input | 1 | One-cycle completed write indication |
| acc_evt | input | 1 | Address or control transition on the array port |
| busy_in | input | 1 | Level read from the shared busy line |
| busy_drive_lo | output | 1 | Pull the shared busy line low |
| inhibit | output | 1 | Array access closed |
| wr_block | output | 1 | Array writes dropped |
| clr_pulse | output | 1 | Start clearing the array |
| copy_pulse | output | 1 | Start copying shadow into the array |
| save_strobe | output | 1 | Start programming the shadow from the array |

## Verification
Every result is due a fixed number of edges after its stimulus. State and drive outputs move at k=1, pulses appear on the first cycle of the phase they start, and each timed phase adds its own parameter to the count. The busy-line trigger lands at k=ASSERT_CYC and the power-fail save attempt adds one cycle. The bench drives each input just after a falling edge and reads the outputs one falling edge per rising edge later, so each check sits at the k the requirement names. For the release of `inhibit` it counts edges until the fall and compares the count with the sum of the phase parameters.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;

  typedef enum logic [3:0] {
    S_OFF   = 4'd0,  // supply low, access closed
    S_RCLR  = 4'd1,  // restore: clearing array
    S_RCPY  = 4'd2,  // restore: copying shadow in
    S_RUN   = 4'd3,  // open access
    S_DLY   = 4'd4,  // busy-line delay window
    S_ATRY  = 4'd5,  // power-fail save attempt
    S_ERASE = 4'd6,  // save: erasing shadow
    S_PROG  = 4'd7,  // save: programming shadow
    S_WHI   = 4'd8,  // waiting for busy line high
    S_REC   = 4'd9   // recovery after line high
  } nvsr_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvsr_timer.sv
module nvsr_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load | (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val - 1'b1;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/nvsr_hold_det.sv
module nvsr_hold_det #(
  parameter int HOLD_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic line_in,
  output logic req
);

  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] LAST = HW'(HOLD_CYC - 1);

  logic [HW-1:0] cnt_q, cnt_d;
  logic          low_seen;

  assign low_seen = en & ~line_in;

  always_comb begin
    if (!low_seen)          cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = cnt_q;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign req = low_seen & (cnt_q == LAST);

  generate
    if (HOLD_CYC > 1) begin : g_chk
      AST_HOLD_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(low_seen)) else $error("hold request without prior low"); // R6
    end
  endgenerate

endmodule

// File: rtl/nvsr_seq.sv
module nvsr_seq
  import nvsr_pkg::*;
#(
  parameter int CLR_CYC    = 16,
  parameter int PUP_CYC    = 55000,
  parameter int SWR_CYC    = 2000,
  parameter int ERASE_CYC  = 500000,
  parameter int PROG_CYC   = 500000,
  parameter int ASSERT_CYC = 25,
  parameter int DLY_CYC    = 100,
  parameter int REC_CYC    = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic sw_store_req,
  input  logic sw_recall_req,
  input  logic wr_strobe,
  input  logic acc_evt,
  input  logic busy_in,
  output logic busy_drive_lo,
  output logic inhibit,
  output logic wr_block,
  output logic clr_pulse,
  output logic copy_pulse,
  output logic save_strobe
);

  localparam int unsigned MAX_CYC = umax(umax(umax(CLR_CYC, PUP_CYC), umax(SWR_CYC, ERASE_CYC)),
                                         umax(umax(PROG_CYC, DLY_CYC), REC_CYC));
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  nvsr_state_e    state_q, state_d;
  logic           pup_q, pup_d;
  logic           dirty_q, dirty_d;
  logic           clr_q, cpy_q, stb_q;
  logic           clr_d, cpy_d, stb_d;
  logic           tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic           ext_req;
  logic           run_open;

  assign run_open = (state_q == S_RUN);

  nvsr_hold_det #(.HOLD_CYC(ASSERT_CYC)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (run_open),
    .line_in (busy_in),
    .req     (ext_req)
  );

  nvsr_timer #(.W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  // next state
  always_comb begin
    state_d = state_q;
    pup_d   = pup_q;
    unique case (state_q)
      S_OFF: begin
        if (pwr_ok) begin
          state_d = S_RCLR;
          pup_d   = 1'b1;
        end
      end
      S_RCLR: begin
        if (!pwr_ok)       state_d = S_OFF;
        else if (tmr_zero) state_d = S_RCPY;
      end
      S_RCPY: begin
        if (!pwr_ok)       state_d = S_OFF;
        else if (tmr_zero) state_d = S_RUN;
      end
      S_RUN: begin
        if (!pwr_ok)            state_d = dirty_q ? S_ATRY : S_OFF;
        else if (sw_store_req)  state_d = S_ERASE;
        else if (sw_recall_req) begin
          state_d = S_RCLR;
          pup_d   = 1'b0;
        end
        else if (ext_req)       state_d = S_DLY;
      end
      S_DLY: begin
        if (!pwr_ok)                   state_d = dirty_q ? S_ATRY : S_OFF;
        else if (tmr_zero || acc_evt)  state_d = dirty_q ? S_ERASE : S_WHI;
      end
      S_ATRY:  state_d = busy_in ? S_OFF : S_ERASE;
      S_ERASE: if (tmr_zero) state_d = S_PROG;
      S_PROG:  if (tmr_zero) state_d = pwr_ok ? S_WHI : S_OFF;
      S_WHI: begin
        if (!pwr_ok)      state_d = S_OFF;
        else if (busy_in) state_d = S_REC;
      end
      S_REC: begin
        if (!pwr_ok)       state_d = S_OFF;
        else if (tmr_zero) state_d = S_RUN;
      end
      default: state_d = S_OFF;
    endcase
  end

  // phase duration for the state being entered
  always_comb begin
    unique case (state_d)
      S_RCLR:  tmr_val = CNT_W'(CLR_CYC);
      S_RCPY:  tmr_val = pup_d ? CNT_W'(PUP_CYC) : CNT_W'(SWR_CYC);
      S_DLY:   tmr_val = CNT_W'(DLY_CYC);
      S_ERASE: tmr_val = CNT_W'(ERASE_CYC);
      S_PROG:  tmr_val = CNT_W'(PROG_CYC);
      S_REC:   tmr_val = CNT_W'(REC_CYC);
      default: tmr_val = CNT_W'(1);
    endcase
  end

  assign tmr_load = (state_d != state_q);

  always_comb begin
    dirty_d = dirty_q;
    if (state_q == S_PROG && tmr_zero) dirty_d = 1'b0;
    else if (run_open && wr_strobe)    dirty_d = 1'b1;
  end

  assign clr_d = (state_d == S_RCLR) && (state_q != S_RCLR);
  assign cpy_d = (state_d == S_RCPY) && (state_q != S_RCPY);
  assign stb_d = (state_d == S_PROG) && (state_q != S_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_OFF;
      pup_q   <= 1'b1;
      dirty_q <= 1'b0;
      clr_q   <= 1'b0;
      cpy_q   <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pup_q   <= pup_d;
      dirty_q <= dirty_d;
      clr_q   <= clr_d;
      cpy_q   <= cpy_d;
      stb_q   <= stb_d;
    end
  end

  assign inhibit       = ~(run_open | (state_q == S_DLY));
  assign wr_block      = ~run_open;
  assign busy_drive_lo = (state_q == S_ATRY) | (state_q == S_ERASE) | (state_q == S_PROG);
  assign clr_pulse     = clr_q;
  assign copy_pulse    = cpy_q;
  assign save_strobe   = stb_q;

  AST_SAVE_CLOSES_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_drive_lo |-> inhibit) else $error("save while access open"); // R4

  AST_COPY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    copy_pulse |-> (state_q == S_RCPY) && ($past(state_q) == S_RCLR)) else $error("copy without clear"); // R2

  AST_WINDOW_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DLY) |-> $past(pwr_ok)) else $error("external save accepted on low power"); // R13

  AST_DIRTY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PROG && tmr_zero) |=> !dirty_q) else $error("pending write survived save"); // R14

  AST_BLOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_block |=> !$rose(dirty_q)) else $error("blocked write counted"); // R8

  AST_ABANDON_ATTEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ATRY && busy_in) |=> !busy_drive_lo && !save_strobe) else $error("attempt not abandoned"); // R12

endmodule

// File: tb/nvsr_seq_bench.sv
module nvsr_seq_bench;

  localparam int CLR = 3, PUP = 10, SWR = 7, ER = 6, PR = 6, AS = 4, DL = 8, RC = 5;

  logic clk = 1'b0;
  logic rst_n, pwr_ok, sw_store_req, sw_recall_req, wr_strobe, acc_evt;
  logic ext_pull, force_hi;
  logic busy_in, busy_drive_lo, inhibit, wr_block, clr_pulse, copy_pulse, save_strobe;
  int nvec = 0, nfail = 0, nclr = 0, ncpy = 0, nstb = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign busy_in = force_hi | ~(busy_drive_lo | ext_pull);

  nvsr_seq #(.CLR_CYC(CLR), .PUP_CYC(PUP), .SWR_CYC(SWR), .ERASE_CYC(ER), .PROG_CYC(PR),
             .ASSERT_CYC(AS), .DLY_CYC(DL), .REC_CYC(RC)) u_nvsr_seq (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .sw_store_req(sw_store_req),
    .sw_recall_req(sw_recall_req), .wr_strobe(wr_strobe), .acc_evt(acc_evt),
    .busy_in(busy_in), .busy_drive_lo(busy_drive_lo), .inhibit(inhibit),
    .wr_block(wr_block), .clr_pulse(clr_pulse), .copy_pulse(copy_pulse),
    .save_strobe(save_strobe)
  );

  always @(negedge clk) if (rst_n) begin
    if (clr_pulse)   nclr++;
    if (copy_pulse)  ncpy++;
    if (save_strobe) nstb++;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // counts edges until inhibit falls, starting at k0
  task automatic wait_open(input int k0, output int k);
    k = k0;
    while (inhibit && k < 500) begin step(); k++; end
  endtask

  task automatic t_reset();
    int k;
    rst_n = 0; pwr_ok = 0; sw_store_req = 0; sw_recall_req = 0;
    wr_strobe = 0; acc_evt = 0; ext_pull = 0; force_hi = 0;
    repeat (3) step();
    rst_n = 1; step();
    chk("R1 inhibit", inhibit, 1);
    chk("R1 wr_block", wr_block, 1);
    chk("R1 drive", busy_drive_lo, 0);
    chk("R1 pulses", clr_pulse | copy_pulse | save_strobe, 0);
    k = 0;
  endtask

  task automatic t_powerup();
    int k, c0, p0;
    c0 = nclr; p0 = ncpy;
    pwr_ok = 1; step();
    chk("R2 clear pulse k1", clr_pulse, 1);
    repeat (CLR) step();
    chk("R2 copy pulse", copy_pulse, 1);
    wait_open(CLR + 1, k);
    chk("R2 inhibit fall", k, CLR + PUP + 1);
    chk("R2 pulse counts", (nclr - c0) * 10 + (ncpy - p0), 11);
  endtask

  task automatic t_sw_store();
    int k, s0;
    s0 = nstb;
    sw_store_req = 1; step(); sw_store_req = 0;
    chk("R4 drive k1", busy_drive_lo, 1);
    repeat (ER) step();
    chk("R4 strobe", save_strobe, 1);
    repeat (PR - 1) step();
    chk("R4 drive last", busy_drive_lo, 1);
    step();
    chk("R4 release", busy_drive_lo, 0);
    chk("R4 still closed", inhibit, 1);
    wait_open(ER + PR + 1, k);
    chk("R5 recovery", k, ER + PR + RC + 2);
    chk("R4 one save", nstb - s0, 1);
  endtask

  task automatic t_ext_clean();
    int k, s0;
    s0 = nstb;
    ext_pull = 1;
    repeat (AS - 1) step();
    chk("R6 not yet", wr_block, 0);
    step();
    chk("R6 window open", inhibit, 0);
    chk("R6 window blocks", wr_block, 1);
    wr_strobe = 1; step(); wr_strobe = 0;
    repeat (DL - 2) step();
    chk("R6 window last", inhibit, 0);
    step();
    chk("R9 closed", inhibit, 1);
    chk("R8 no save drive", busy_drive_lo, 0);
    repeat (5) step();
    chk("R9 held", inhibit, 1);
    ext_pull = 0;
    wait_open(0, k);
    chk("R9 recovery", k, RC + 1);
    chk("R8 no strobe", nstb - s0, 0);
  endtask

  task automatic t_ext_dirty();
    int k, s0;
    s0 = nstb;
    wr_strobe = 1; step(); wr_strobe = 0;
    ext_pull = 1;
    repeat (AS) step();
    chk("R7 in window", inhibit, 0);
    acc_evt = 1; step(); acc_evt = 0;
    chk("R7 early save", busy_drive_lo, 1);
    repeat (ER + PR) step();
    chk("R5 released", busy_drive_lo, 0);
    repeat (8) step();
    chk("R5 shared hold", inhibit, 1);
    ext_pull = 0;
    wait_open(0, k);
    chk("R5 recovery", k, RC + 1);
    chk("R7 one save", nstb - s0, 1);
  endtask

  task automatic t_off_clean();
    int c0, s0;
    c0 = nclr; s0 = nstb;
    pwr_ok = 0; step();
    chk("R11 no drive", busy_drive_lo, 0);
    chk("R14 flag cleared", nstb - s0, 0);
    ext_pull = 1; repeat (10) step();
    chk("R13 ext ignored", busy_drive_lo, 0);
    ext_pull = 0;
    sw_store_req = 1; step(); sw_store_req = 0;
    chk("R13 store ignored", busy_drive_lo, 0);
    sw_recall_req = 1; step(); sw_recall_req = 0;
    step();
    chk("R13 recall ignored", nclr - c0, 0);
    chk("R13 no save", nstb - s0, 0);
  endtask

  task automatic t_sw_recall();
    int k, c0;
    sw_recall_req = 1; step(); sw_recall_req = 0;
    chk("R3 clear pulse", clr_pulse, 1);
    wait_open(1, k);
    chk("R3 inhibit fall", k, CLR + SWR + 1);
    c0 = nclr;
    sw_store_req = 1; step(); sw_store_req = 0;
    sw_recall_req = 1; step(); sw_recall_req = 0;
    repeat (ER + PR) step();
    wait_open(0, k);
    chk("R13 recall during save", nclr - c0, 0);
  endtask

  task automatic t_pfail_dirty();
    int s0;
    s0 = nstb;
    wr_strobe = 1; step(); wr_strobe = 0;
    pwr_ok = 0; step();
    chk("R10 attempt k1", busy_drive_lo, 1);
    step();
    chk("R10 erase k2", busy_drive_lo, 1);
    repeat (ER) step();
    chk("R10 strobe", save_strobe, 1);
    repeat (PR) step();
    chk("R10 release", busy_drive_lo, 0);
    chk("R10 closed", inhibit, 1);
    chk("R10 one save", nstb - s0, 1);
  endtask

  task automatic t_abandon();
    int s0;
    s0 = nstb;
    wr_strobe = 1; step(); wr_strobe = 0;
    force_hi = 1;
    pwr_ok = 0; step();
    chk("R12 attempt", busy_drive_lo, 1);
    step();
    chk("R12 abandoned", busy_drive_lo, 0);
    repeat (ER + PR) step();
    chk("R12 no save", nstb - s0, 0);
    force_hi = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R1 actual=1 expected=0");
    summary();
  end

  initial begin
    t_reset();
    t_powerup();
    t_sw_store();
    t_ext_clean();
    t_ext_dirty();
    t_off_clean();
    t_powerup();
    t_sw_recall();
    t_pfail_dirty();
    t_powerup();
    t_abandon();
    summary();
  end

endmodule